// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the register front end of a four-channel DMA controller in the classic 8-bit I/O style. Software sees a small bank of byte-wide ports. For each channel it can program a 16-bit start address and a 16-bit transfer count, an 8-bit page and a mode field. A shared command register, a channel mask, a software request register and a status register serve all four channels. Both halves of a 16-bit value go through the same byte port. A single byte-pointer flip-flop decides which half each access touches and toggles after each address or count access.

A transfer engine, which is outside this block, reads the programmed values from dedicated output ports. It reports the end of a channel's transfer with a one-cycle terminal-count pulse, and that pulse latches into the status register. Reads are registered: `rd_data` shows the requested byte on the cycle after the read strobe. The byte pointer is a two-state machine with the states PTR_LO and PTR_HI. The transition STEP (PTR_LO to PTR_HI, or PTR_HI to PTR_LO) is taken on every address or count access. The transition CLEAR (any state to PTR_LO) is taken on a clear-pointer write or a master-reset write, and CLEAR wins over STEP.

Port map (5-bit `port_addr`): 0x00–0x07 are the channel ports, where channel = bits 2:1 and bit 0 selects address (0) or count (1). 0x08 is command on write and status on read. 0x09 is request, 0x0A is single mask, 0x0B is mode, 0x0C is clear pointer, 0x0D is master reset, 0x0E is clear mask and 0x0F is load all masks. 0x10–0x13 are the pages of channels 0–3. Status bits 3:0 are the terminal-count flags of channels 3..0, and bits 7:4 show the software request bits of channels 3..0.

Top module: `legacy_dma_regs`

## Requirements
- R1: A write to a channel address port stores the byte into both the base and current address of that channel. The byte goes to the low byte when the pointer is PTR_LO and to the high byte when it is PTR_HI, and the pointer then toggles.
- R2: A write to a channel count port stores the byte into both the base and current count, using and toggling the same shared pointer.
- R3: A read of an address or count port returns the pointer-selected byte of the current value on the following cycle, and toggles the pointer.
- R4: The page ports (0x10–0x13) read and write a plain 8-bit register per channel and leave the pointer unchanged.
- R5: On a write to 0x0A, bits 1:0 pick the channel. Bit 2 = 1 sets that channel's mask bit. Bit 2 = 0 clears the mask bit and also clears that channel's status flag.
- R6: On a write to 0x0B, bits 1:0 pick the channel and bits 7:2 become its 6-bit mode (`mode_o` bits [6c+5:6c]).
- R7: On a write to 0x09, bits 1:0 pick the channel and bit 2 sets (1) or clears (0) its software request bit. The request bits appear on `req_o` and in status bits 7:4.
- R8: A write to 0x0C forces the pointer to PTR_LO.
- R9: A write to 0x0D clears the command, status flags, requests and pointer and sets all four mask bits. Channel registers are kept.
- R10: A write to 0x0E clears every mask bit. A write to 0x0F loads the mask from data bits 3:0. Both clear status bits 3:0.
- R11: A read of 0x08 returns the full status and then clears bits 3:0. Bits 7:4 are kept, and a terminal-count pulse in the same cycle still sets its flag.
- R12: A high `tc_in[c]` sets status bit c.
- R13: A read of any port with no readable register (0x09–0x0F, 0x14–0x1F) returns 0xFF.
- R14: A write to 0x08 loads the command register, which is visible on `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_addr | input | 5 | Port address of the current access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, ignored when `wr_en` is high |
| rd_data | output | 8 | Registered read data |
| tc_in | input | 4 | Per-channel terminal-count pulses |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| mode_o | output | 24 | Mode fields, 6 bits per channel |
| page_o | output | 32 | Page registers, 8 bits per channel |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |

## Verification
The hardest case to reach is a terminal-count pulse that lands on the same edge as a status read. The read must return the old flags while the new flag survives the clear. The bench drives the pulse and the read strobe in the same cycle, then reads status again to see the flag. Pointer state is only visible through the byte it steers. So page accesses and master reset are placed between two halves of a 16-bit write, and the bench checks which byte lane the second half lands in.

// File: rtl/legacy_dma_pkg.sv
package legacy_dma_pkg;

    typedef enum logic [3:0] {
        PK_NONE,
        PK_ADDR,
        PK_CNT,
        PK_PAGE,
        PK_STAT_CMD,
        PK_REQ,
        PK_SMASK,
        PK_MODE,
        PK_CLRFF,
        PK_MRST,
        PK_CLRMASK,
        PK_ALLMASK
    } port_kind_e;

    typedef enum logic {
        PTR_LO,
        PTR_HI
    } ptr_state_e;

endpackage

// File: rtl/legacy_dma_byteptr.sv
module legacy_dma_byteptr
    import legacy_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic hi_o
);

    ptr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = PTR_LO;
        end else if (step_i) begin
            unique case (state_q)
                PTR_LO: state_d = PTR_HI;
                PTR_HI: state_d = PTR_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb hi_o = (state_q == PTR_HI);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=> (hi_o != $past(hi_o)));   // R1
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !hi_o);                                 // R8

endmodule

// File: rtl/legacy_dma_chan.sv
module legacy_dma_chan #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_addr_i,
    input  logic                  wr_cnt_i,
    input  logic                  wr_page_i,
    input  logic                  wr_mode_i,
    input  logic                  hi_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   base_addr_o,
    output logic [2*DATA_W-1:0]   cur_addr_o,
    output logic [2*DATA_W-1:0]   base_cnt_o,
    output logic [2*DATA_W-1:0]   cur_cnt_o,
    output logic [DATA_W-1:0]     page_o,
    output logic [DATA_W-3:0]     mode_o
);

    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;
    logic [DATA_W-1:0] page_q;
    logic [DATA_W-3:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            cur_addr_q  <= '0;
            base_cnt_q  <= '0;
            cur_cnt_q   <= '0;
            page_q      <= '0;
            mode_q      <= '0;
        end else begin
            if (wr_addr_i) begin
                if (hi_i) begin
                    base_addr_q[WIDE_W-1:DATA_W] <= wdata_i;
                    cur_addr_q[WIDE_W-1:DATA_W]  <= wdata_i;
                end else begin
                    base_addr_q[DATA_W-1:0] <= wdata_i;
                    cur_addr_q[DATA_W-1:0]  <= wdata_i;
                end
            end
            if (wr_cnt_i) begin
                if (hi_i) begin
                    base_cnt_q[WIDE_W-1:DATA_W] <= wdata_i;
                    cur_cnt_q[WIDE_W-1:DATA_W]  <= wdata_i;
                end else begin
                    base_cnt_q[DATA_W-1:0] <= wdata_i;
                    cur_cnt_q[DATA_W-1:0]  <= wdata_i;
                end
            end
            if (wr_page_i) page_q <= wdata_i;
            if (wr_mode_i) mode_q <= wdata_i[DATA_W-1:2];
        end
    end

    assign base_addr_o = base_addr_q;
    assign cur_addr_o  = cur_addr_q;
    assign base_cnt_o  = base_cnt_q;
    assign cur_cnt_o   = cur_cnt_q;
    assign page_o      = page_q;
    assign mode_o      = mode_q;

    AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_i |=> (base_addr_o == cur_addr_o));             // R1
    AST_CNT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (base_cnt_o == cur_cnt_o));                // R2
    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_page_i |=> (page_o == $past(wdata_i)));              // R4

endmodule

// File: rtl/legacy_dma_ctrl.sv
module legacy_dma_ctrl #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst_i,
    input  logic                      cmd_we_i,
    input  logic                      req_we_i,
    input  logic                      smask_we_i,
    input  logic                      allmask_we_i,
    input  logic                      clrmask_we_i,
    input  logic                      stat_rd_i,
    input  logic [$clog2(NUM_CH)-1:0] sel_i,
    input  logic                      set_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NUM_CH-1:0]         tc_i,
    output logic [DATA_W-1:0]         cmd_o,
    output logic [NUM_CH-1:0]         mask_o,
    output logic [NUM_CH-1:0]         req_o,
    output logic [2*NUM_CH-1:0]       stat_o
);

    logic [DATA_W-1:0] cmd_q;
    logic [NUM_CH-1:0] mask_q, req_q, flag_q, flag_clr, flag_d;

    always_comb begin
        flag_clr = '0;
        if (stat_rd_i || allmask_we_i || clrmask_we_i) flag_clr = '1;
        if (smask_we_i && !set_i) flag_clr[sel_i] = 1'b1;
        flag_d = (flag_q & ~flag_clr) | tc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mask_q <= '1;
            req_q  <= '0;
            flag_q <= '0;
        end else if (soft_rst_i) begin
            cmd_q  <= '0;
            mask_q <= '1;
            req_q  <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (cmd_we_i) cmd_q <= wdata_i;
            if (req_we_i) req_q[sel_i] <= set_i;
            if (smask_we_i) mask_q[sel_i] <= set_i;
            else if (clrmask_we_i) mask_q <= '0;
            else if (allmask_we_i) mask_q <= wdata_i[NUM_CH-1:0];
        end
    end

    assign cmd_o  = cmd_q;
    assign mask_o = mask_q;
    assign req_o  = req_q;
    assign stat_o = {req_q, flag_q};

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (mask_o == '1 && cmd_o == '0 && req_o == '0));       // R9
    AST_STAT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && tc_i == '0) |=> (stat_o[NUM_CH-1:0] == '0));          // R11
    AST_STAT_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !soft_rst_i && !req_we_i) |=> $stable(stat_o[2*NUM_CH-1:NUM_CH])); // R11
    AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i != '0 && !soft_rst_i) |=> ((stat_o[NUM_CH-1:0] & $past(tc_i)) == $past(tc_i))); // R12

endmodule

// File: rtl/legacy_dma_regs.sv
module legacy_dma_regs
    import legacy_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              port_addr,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rd_en,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [NUM_CH-1:0]              tc_in,
    output logic [DATA_W-1:0]              cmd_o,
    output logic [NUM_CH-1:0]              mask_o,
    output logic [NUM_CH-1:0]              req_o,
    output logic [NUM_CH*(DATA_W-2)-1:0]   mode_o,
    output logic [NUM_CH*DATA_W-1:0]       page_o,
    output logic [NUM_CH*2*DATA_W-1:0]     base_addr_o,
    output logic [NUM_CH*2*DATA_W-1:0]     base_cnt_o
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int MODE_W = DATA_W - 2;

    port_kind_e      kind;
    logic [CH_W-1:0] chan;
    logic            rd_go, ptr_hi, ptr_step, ptr_clear;
    logic [2*NUM_CH-1:0] stat;
    logic [DATA_W-1:0]   rd_d;

    logic [WIDE_W-1:0] cur_addr_a [NUM_CH];
    logic [WIDE_W-1:0] cur_cnt_a  [NUM_CH];
    logic [DATA_W-1:0] page_a     [NUM_CH];

    always_comb begin
        kind = PK_NONE;
        chan = '0;
        if (!port_addr[4]) begin
            if (!port_addr[3]) begin
                chan = port_addr[CH_W:1];
                kind = port_addr[0] ? PK_CNT : PK_ADDR;
            end else begin
                unique case (port_addr[2:0])
                    3'd0: kind = PK_STAT_CMD;
                    3'd1: kind = PK_REQ;
                    3'd2: kind = PK_SMASK;
                    3'd3: kind = PK_MODE;
                    3'd4: kind = PK_CLRFF;
                    3'd5: kind = PK_MRST;
                    3'd6: kind = PK_CLRMASK;
                    3'd7: kind = PK_ALLMASK;
                endcase
            end
        end else if (port_addr[3:2] == 2'b00) begin
            chan = port_addr[CH_W-1:0];
            kind = PK_PAGE;
        end
    end

    assign rd_go     = rd_en && !wr_en;
    assign ptr_step  = (wr_en || rd_go) && (kind == PK_ADDR || kind == PK_CNT);
    assign ptr_clear = wr_en && (kind == PK_CLRFF || kind == PK_MRST);

    legacy_dma_byteptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (ptr_step),
        .clear_i (ptr_clear),
        .hi_o    (ptr_hi)
    );

    legacy_dma_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (wr_en && kind == PK_MRST),
        .cmd_we_i     (wr_en && kind == PK_STAT_CMD),
        .req_we_i     (wr_en && kind == PK_REQ),
        .smask_we_i   (wr_en && kind == PK_SMASK),
        .allmask_we_i (wr_en && kind == PK_ALLMASK),
        .clrmask_we_i (wr_en && kind == PK_CLRMASK),
        .stat_rd_i    (rd_go && kind == PK_STAT_CMD),
        .sel_i        (wr_data[CH_W-1:0]),
        .set_i        (wr_data[2]),
        .wdata_i      (wr_data),
        .tc_i         (tc_in),
        .cmd_o        (cmd_o),
        .mask_o       (mask_o),
        .req_o        (req_o),
        .stat_o       (stat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [WIDE_W-1:0] base_addr_w, base_cnt_w;
        logic [MODE_W-1:0] mode_w;

        legacy_dma_chan #(.DATA_W(DATA_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_addr_i   (wr_en && kind == PK_ADDR && chan == c),
            .wr_cnt_i    (wr_en && kind == PK_CNT  && chan == c),
            .wr_page_i   (wr_en && kind == PK_PAGE && chan == c),
            .wr_mode_i   (wr_en && kind == PK_MODE && wr_data[CH_W-1:0] == c),
            .hi_i        (ptr_hi),
            .wdata_i     (wr_data),
            .base_addr_o (base_addr_w),
            .cur_addr_o  (cur_addr_a[c]),
            .base_cnt_o  (base_cnt_w),
            .cur_cnt_o   (cur_cnt_a[c]),
            .page_o      (page_a[c]),
            .mode_o      (mode_w)
        );

        assign base_addr_o[c*WIDE_W +: WIDE_W] = base_addr_w;
        assign base_cnt_o[c*WIDE_W +: WIDE_W]  = base_cnt_w;
        assign page_o[c*DATA_W +: DATA_W]      = page_a[c];
        assign mode_o[c*MODE_W +: MODE_W]      = mode_w;
    end

    always_comb begin
        rd_d = '1;
        unique case (kind)
            PK_ADDR:     rd_d = ptr_hi ? cur_addr_a[chan][WIDE_W-1:DATA_W] : cur_addr_a[chan][DATA_W-1:0];
            PK_CNT:      rd_d = ptr_hi ? cur_cnt_a[chan][WIDE_W-1:DATA_W]  : cur_cnt_a[chan][DATA_W-1:0];
            PK_PAGE:     rd_d = page_a[chan];
            PK_STAT_CMD: rd_d = DATA_W'(stat);
            default:     rd_d = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_go) rd_data <= rd_d;
    end

    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !(kind inside {PK_ADDR, PK_CNT, PK_PAGE, PK_STAT_CMD})) |=> (rd_data == '1)); // R13
    AST_PAGE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_go) && kind == PK_PAGE) |=> $stable(ptr_hi));                           // R4

endmodule

// File: tb/legacy_dma_regs_tb.sv
module legacy_dma_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  port_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  tc_in = '0;
    logic [7:0]  cmd_o;
    logic [3:0]  mask_o, req_o;
    logic [23:0] mode_o;
    logic [31:0] page_o;
    logic [63:0] base_addr_o, base_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    legacy_dma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tc_in(tc_in),
        .cmd_o(cmd_o), .mask_o(mask_o), .req_o(req_o), .mode_o(mode_o),
        .page_o(page_o), .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o)
    );

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag,
                      input logic [3:0] tc = 4'b0);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        port_addr = a; rd_en = 1'b1; tc_in = tc;
        @(negedge clk);
        rd_en = 1'b0; tc_in = '0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk);
        tc_in = v;
        @(negedge clk);
        tc_in = '0;
    endtask

    // monitor: pop expected read data one cycle after each read strobe
    always @(posedge clk) begin
        if (rd_en && !wr_en) begin
            #1;
            if (exp_q.size() == 0) begin
                chk(1, 0, "scoreboard underflow");
            end else begin
                chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rd_data, 8'h00, "reset rd_data");
        chk(mask_o, 4'hF, "R9 reset mask");
        chk(cmd_o, 8'h00, "R14 reset cmd");
        chk(req_o, 4'h0, "R7 reset req");

        // R1: low then high byte of channel 1 address
        wr(5'h02, 8'h34);
        wr(5'h02, 8'h12);
        chk(base_addr_o[31:16], 16'h1234, "R1 base addr ch1");
        // R3: read current address back, low then high
        rd(5'h02, 8'h34, "R3 addr lo ch1");
        rd(5'h02, 8'h12, "R3 addr hi ch1");

        // R2 + R4: page access between the two count halves
        wr(5'h01, 8'hCD);
        wr(5'h11, 8'hAB);
        rd(5'h11, 8'hAB, "R4 page ch1 read");
        wr(5'h01, 8'h0E);
        chk(base_cnt_o[15:0], 16'h0ECD, "R2 R4 base count ch0");
        chk(page_o[15:8], 8'hAB, "R4 page ch1 port");
        rd(5'h01, 8'hCD, "R3 cnt lo ch0");
        rd(5'h01, 8'h0E, "R3 cnt hi ch0");

        // R8: clear pointer between halves
        wr(5'h06, 8'h55);
        wr(5'h0C, 8'h00);
        wr(5'h06, 8'h66);
        chk(base_addr_o[63:48], 16'h0066, "R8 clear ptr ch3");
        wr(5'h0C, 8'h00);

        // R6: mode write to channel 2
        wr(5'h0B, 8'hB6);
        chk(mode_o[17:12], 6'h2D, "R6 mode ch2");
        chk(mode_o[11:6], 6'h00, "R6 mode ch1 untouched");

        // R12 + R5
        pulse_tc(4'b0010);
        pulse_tc(4'b0100);
        wr(5'h0A, 8'h01);
        chk(mask_o, 4'hD, "R5 unmask ch1");
        rd(5'h08, 8'h04, "R5 R12 status after unmask");
        rd(5'h08, 8'h00, "R11 status cleared");
        wr(5'h0A, 8'h06);
        chk(mask_o, 4'hD, "R5 mask ch2");
        wr(5'h0A, 8'h02);
        chk(mask_o, 4'h9, "R5 unmask ch2");

        // R7
        wr(5'h09, 8'h07);
        wr(5'h09, 8'h05);
        wr(5'h09, 8'h03);
        chk(req_o, 4'h2, "R7 request bits");
        rd(5'h08, 8'h20, "R7 request in status");

        // R11 + R12
        pulse_tc(4'b1001);
        rd(5'h08, 8'h29, "R11 status full");
        rd(5'h08, 8'h20, "R11 low nibble cleared");
        rd(5'h08, 8'h20, "R11 read with tc", 4'b0001);
        rd(5'h08, 8'h21, "R11 tc same cycle kept");
        rd(5'h08, 8'h20, "R11 cleared again");

        // R10
        pulse_tc(4'b0011);
        wr(5'h0F, 8'h05);
        chk(mask_o, 4'h5, "R10 load all masks");
        rd(5'h08, 8'h20, "R10 all-mask clears flags");
        pulse_tc(4'b0100);
        wr(5'h0E, 8'h00);
        chk(mask_o, 4'h0, "R10 clear masks");
        rd(5'h08, 8'h20, "R10 clear-mask clears flags");

        // R14
        wr(5'h08, 8'hC3);
        chk(cmd_o, 8'hC3, "R14 command");

        // R13
        rd(5'h1F, 8'hFF, "R13 unmapped 0x1F");
        rd(5'h0A, 8'hFF, "R13 write-only 0x0A");
        rd(5'h14, 8'hFF, "R13 unmapped 0x14");

        // R9: reset while pointer is high
        wr(5'h00, 8'h77);
        pulse_tc(4'b0001);
        wr(5'h0D, 8'h00);
        chk(mask_o, 4'hF, "R9 mask set");
        chk(cmd_o, 8'h00, "R9 cmd cleared");
        chk(req_o, 4'h0, "R9 req cleared");
        rd(5'h08, 8'h00, "R9 status cleared");
        wr(5'h00, 8'h99);
        chk(base_addr_o[15:0], 16'h0099, "R9 pointer low");
        chk(base_addr_o[31:16], 16'h1234, "R9 channel regs kept");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "scoreboard drained");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule